// File: doc/BRIEF.md
# Mixed-Width Dual-Port Byte RAM

This block is a single-clock, true dual-port memory of 4 KiB. The storage is seen through two ports of different widths. The narrow port moves one byte per access and takes a 12-bit byte address. The wide port moves one 32-bit word per access, takes a 10-bit word address and has one write enable per byte lane. Both ports index the same array of 1024 words with four byte lanes each. A byte written through either port is therefore visible through the other at once, with no conversion stage in between.

Each port has its own read strobe, write strobe, address, write data and a read data register. Reads and writes are taken on the rising clock edge. Read data appears in the cycle after the strobe was sampled. The same-cycle behaviour is fixed. A read sees the contents from before any write in that cycle. If both ports write one byte in the same cycle, the wide port's value is kept.

The block has no control state machine: every access completes in one edge. The work is split into three parts: per-lane storage, the lane select for the narrow port, and the two read registers.

Top module: `mwram_top`

## Requirements
- R1: A narrow-port byte address selects word `a_addr[11:2]` and lane `a_addr[1:0]`. Lane 0 is wide-port data bits 7:0 and lane 3 is bits 31:24 (little-endian).
- R2: A wide-port write (`b_wr`=1) updates exactly those lanes of word `b_addr` whose `b_ben` bit is 1. All other lanes keep their contents.
- R3: A narrow-port write changes the addressed byte only when both `a_wr` and `a_ben` are 1. With `a_ben`=0 the byte is unchanged.
- R4: Read data is registered. `a_rdata`/`b_rdata` show the addressed contents in the cycle after the edge that sampled the read strobe high.
- R5: In a cycle where a port's read strobe is low, its read data register keeps its previous value, whatever the other inputs do.
- R6: When both ports write the same byte on one edge, the byte takes the wide port's value. A narrow-port write to a lane that the wide port does not enable in the same word still takes effect.
- R7: A read that is sampled on the same edge as a write to the same byte by the other port returns the old contents. The next read returns the new contents.
- R8: While `rst_n` is low, both read data registers are cleared to zero asynchronously. Stored contents are not reset.
- R9: Bytes written through one port read back through the other port in the lane given by R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset of the read registers |
| a_rd | input | 1 | Narrow-port read strobe |
| a_wr | input | 1 | Narrow-port write strobe |
| a_ben | input | 1 | Narrow-port byte enable |
| a_addr | input | 12 | Narrow-port byte address |
| a_wdata | input | 8 | Narrow-port write data |
| a_rdata | output | 8 | Narrow-port registered read data |
| b_rd | input | 1 | Wide-port read strobe |
| b_wr | input | 1 | Wide-port write strobe |
| b_ben | input | 4 | Wide-port byte lane enables, bit n for lane n |
| b_addr | input | 10 | Wide-port word address |
| b_wdata | input | 32 | Wide-port write data |
| b_rdata | output | 32 | Wide-port registered read data |

## Verification
The storage assertions assume that every write address and write data is a known value whenever its enable is sampled high. They also assume `rst_n` starts low, so the read registers hold defined values before the first hold check. The bench drives all inputs only just after the falling edge and never leaves an address undriven while a strobe is high. It begins with reset asserted. Same-byte collisions are driven deliberately with distinct data, so the assertion on the wide port's priority sees real conflicts rather than identical values.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int unsigned MW_BYTE_W = 8;
    localparam int unsigned MW_LANES  = 4;

    typedef logic [MW_BYTE_W-1:0] mw_byte_t;

endpackage

// File: rtl/mwram_lane.sv
module mwram_lane #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Narrow-port write first, wide-port write last: wide port keeps a shared cell
    always_ff @(posedge clk) begin
        if (wa_en) cells[wa_addr] <= wa_data;
        if (wb_en) cells[wb_addr] <= wb_data;
    end

    // Combinational read; the capturing registers sit in the top, so reads see old data
    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];

    // R2: an enabled wide-port lane write always lands
    a_r2_b_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> cells[$past(wb_addr)] == $past(wb_data));

    // R3: an uncontested narrow-port write lands
    a_r3_a_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && !(wb_en && wb_addr == wa_addr)) |=> cells[$past(wa_addr)] == $past(wa_data));

    // R6: same-cell collision keeps the wide port's byte
    a_r6_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_addr == wb_addr) |=> cells[$past(wa_addr)] == $past(wb_data));

endmodule

// File: rtl/mwram_rdreg.sv
module mwram_rdreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

endmodule

// File: rtl/mwram_top.sv
module mwram_top #(
    parameter int WORD_AW = 10
) (
    input  logic                                                      clk,
    input  logic                                                      rst_n,
    input  logic                                                      a_rd,
    input  logic                                                      a_wr,
    input  logic                                                      a_ben,
    input  logic [WORD_AW+$clog2(mwram_pkg::MW_LANES)-1:0]            a_addr,
    input  logic [mwram_pkg::MW_BYTE_W-1:0]                           a_wdata,
    output logic [mwram_pkg::MW_BYTE_W-1:0]                           a_rdata,
    input  logic                                                      b_rd,
    input  logic                                                      b_wr,
    input  logic [mwram_pkg::MW_LANES-1:0]                            b_ben,
    input  logic [WORD_AW-1:0]                                        b_addr,
    input  logic [mwram_pkg::MW_LANES*mwram_pkg::MW_BYTE_W-1:0]       b_wdata,
    output logic [mwram_pkg::MW_LANES*mwram_pkg::MW_BYTE_W-1:0]       b_rdata
);

    import mwram_pkg::*;

    localparam int LANES   = MW_LANES;
    localparam int BYTE_W  = MW_BYTE_W;
    localparam int LANE_AW = $clog2(LANES);
    localparam int A_AW    = WORD_AW + LANE_AW;
    localparam int B_DW    = LANES * BYTE_W;

    logic [WORD_AW-1:0] a_word;
    logic [LANE_AW-1:0] a_lane;
    mw_byte_t           a_lane_q [LANES];
    logic [B_DW-1:0]    b_word_q;
    mw_byte_t           a_byte_q;

    // R1: byte address splits into word index and little-endian lane
    assign a_word = a_addr[A_AW-1:LANE_AW];
    assign a_lane = a_addr[LANE_AW-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_wa_en;
        logic lane_wb_en;

        assign lane_wa_en = a_wr && a_ben && (a_lane == LANE_AW'(g));
        assign lane_wb_en = b_wr && b_ben[g];

        mwram_lane #(
            .AW (WORD_AW),
            .DW (BYTE_W)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wa_en   (lane_wa_en),
            .wa_addr (a_word),
            .wa_data (a_wdata),
            .wb_en   (lane_wb_en),
            .wb_addr (b_addr),
            .wb_data (b_wdata[g*BYTE_W +: BYTE_W]),
            .ra_addr (a_word),
            .rb_addr (b_addr),
            .ra_data (a_lane_q[g]),
            .rb_data (b_word_q[g*BYTE_W +: BYTE_W])
        );
    end

    assign a_byte_q = a_lane_q[a_lane];

    mwram_rdreg #(.W(BYTE_W)) i_rdreg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (a_rd),
        .d     (a_byte_q),
        .q     (a_rdata)
    );

    mwram_rdreg #(.W(B_DW)) i_rdreg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (b_rd),
        .d     (b_word_q),
        .q     (b_rdata)
    );

    // R5: read registers hold while their strobe is low
    a_r5_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rd |=> $stable(a_rdata));

    a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rd |=> $stable(b_rdata));

endmodule

// File: tb/test_mwram_top.sv
module test_mwram_top;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 1024;
    localparam int NBYTES     = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_rd, a_wr, a_ben;
    logic [11:0] a_addr;
    logic [7:0]  a_wdata, a_rdata;
    logic        b_rd, b_wr;
    logic [3:0]  b_ben;
    logic [9:0]  b_addr;
    logic [31:0] b_wdata, b_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mdl [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwram_top i_mwram_top (
        .clk(clk), .rst_n(rst_n),
        .a_rd(a_rd), .a_wr(a_wr), .a_ben(a_ben), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_rd(b_rd), .b_wr(b_wr), .b_ben(b_ben), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    function automatic logic [7:0] pat(input int k, input int salt);
        return 8'((k * 37 + salt) ^ (k >> 4));
    endfunction

    function automatic logic [31:0] mword(input int w);
        return {mdl[4*w+3], mdl[4*w+2], mdl[4*w+1], mdl[4*w]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        a_rd = 0; a_wr = 0; a_ben = 0; b_rd = 0; b_wr = 0; b_ben = 4'h0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  old_b;
        logic [31:0] old_w;
        rst_n = 0; idle();
        a_addr = '0; a_wdata = '0; b_addr = '0; b_wdata = '0;
        tick(); tick();
        // R8: reset clears both read registers
        check("R8", {24'h0, a_rdata}, 32'h0);
        check("R8", b_rdata, 32'h0);
        rst_n = 1;
        tick();

        // Fill every word through the wide port
        for (int w = 0; w < NWORDS; w++) begin
            b_wr = 1; b_ben = 4'hF; b_addr = 10'(w);
            b_wdata = {pat(4*w+3, 1), pat(4*w+2, 1), pat(4*w+1, 1), pat(4*w, 1)};
            for (int l = 0; l < 4; l++) mdl[4*w+l] = b_wdata[8*l +: 8];
            tick();
        end
        idle();

        // R1 R4 R9: every byte read through the narrow port, one-cycle latency
        for (int ba = 0; ba < NBYTES; ba++) begin
            a_rd = 1; a_addr = 12'(ba);
            tick();
            check("R1", {24'h0, a_rdata}, {24'h0, mdl[ba]});
        end
        idle();

        // R3: narrow writes, enable cleared on every third byte
        for (int ba = 0; ba < NBYTES; ba++) begin
            a_wr = 1; a_ben = (ba % 3 != 0); a_addr = 12'(ba); a_wdata = pat(ba, 77);
            if (a_ben) mdl[ba] = a_wdata;
            tick();
        end
        idle();
        for (int w = 0; w < NWORDS; w++) begin
            b_rd = 1; b_addr = 10'(w);
            tick();
            check("R3 R9", b_rdata, mword(w));
        end
        idle();

        // R2: partial-lane wide writes, enable pattern taken from word index
        for (int w = 0; w < NWORDS; w++) begin
            b_wr = 1; b_ben = 4'(w); b_addr = 10'(w);
            b_wdata = {pat(4*w+3, 11), pat(4*w+2, 11), pat(4*w+1, 11), pat(4*w, 11)};
            for (int l = 0; l < 4; l++) if (b_ben[l]) mdl[4*w+l] = b_wdata[8*l +: 8];
            tick();
        end
        idle();
        for (int w = 0; w < NWORDS; w++) begin
            b_rd = 1; b_addr = 10'(w);
            tick();
            check("R2", b_rdata, mword(w));
        end
        idle();

        // R5: narrow read register holds while its strobe is low
        a_rd = 1; a_addr = 12'd5;
        tick();
        old_b = a_rdata;
        check("R4", {24'h0, a_rdata}, {24'h0, mdl[5]});
        for (int i = 0; i < 3; i++) begin
            idle();
            a_addr = 12'(9 + i);
            b_wr = 1; b_ben = 4'hF; b_addr = 10'd1; b_wdata = 32'h5A5A_5A00 + 32'(i);
            for (int l = 0; l < 4; l++) mdl[4+l] = b_wdata[8*l +: 8];
            tick();
            check("R5", {24'h0, a_rdata}, {24'h0, old_b});
        end
        idle();

        // R5: wide read register holds while its strobe is low
        b_rd = 1; b_addr = 10'd7;
        tick();
        old_w = b_rdata;
        check("R4", b_rdata, mword(7));
        for (int l = 0; l < 4; l++) begin
            idle();
            b_addr = 10'(20 + l);
            a_wr = 1; a_ben = 1; a_addr = 12'(28 + l); a_wdata = 8'hE0 + 8'(l);
            mdl[28+l] = a_wdata;
            tick();
            check("R5", b_rdata, old_w);
        end
        idle();
        b_rd = 1; b_addr = 10'd7;
        tick();
        check("R9", b_rdata, mword(7));
        idle();

        // R6: same-byte collision on each lane, wide port wins
        for (int l = 0; l < 4; l++) begin
            a_wr = 1; a_ben = 1; a_addr = 12'(4*(100+l) + l); a_wdata = 8'hA0 + 8'(l);
            b_wr = 1; b_ben = 4'hF; b_addr = 10'(100 + l); b_wdata = 32'hC3C2_C1C0 + 32'(l << 4);
            for (int k = 0; k < 4; k++) mdl[4*(100+l)+k] = b_wdata[8*k +: 8];
            tick();
        end
        // R6: narrow write to a lane the wide port leaves disabled still lands
        for (int l = 0; l < 4; l++) begin
            a_wr = 1; a_ben = 1; a_addr = 12'(4*(110+l) + l); a_wdata = 8'h90 + 8'(l);
            b_wr = 1; b_ben = ~(4'b0001 << l); b_addr = 10'(110 + l); b_wdata = 32'h7766_5544;
            for (int k = 0; k < 4; k++) if (b_ben[k]) mdl[4*(110+l)+k] = b_wdata[8*k +: 8];
            mdl[4*(110+l)+l] = a_wdata;
            tick();
        end
        idle();
        for (int w = 100; w < 114; w++) begin
            if (w < 104 || w >= 110) begin
                b_rd = 1; b_addr = 10'(w);
                tick();
                check("R6", b_rdata, mword(w));
            end
        end
        idle();

        // R7: narrow read while wide port writes the same byte
        a_rd = 1; a_addr = 12'(4*200 + 2);
        b_wr = 1; b_ben = 4'hF; b_addr = 10'd200; b_wdata = 32'h1122_3344;
        old_b = mdl[4*200+2];
        for (int k = 0; k < 4; k++) mdl[4*200+k] = b_wdata[8*k +: 8];
        tick();
        check("R7", {24'h0, a_rdata}, {24'h0, old_b});
        b_wr = 0; b_ben = 4'h0;
        tick();
        check("R7", {24'h0, a_rdata}, 32'h22);
        idle();

        // R7: wide read while narrow port writes a byte of that word
        b_rd = 1; b_addr = 10'd300;
        a_wr = 1; a_ben = 1; a_addr = 12'(4*300 + 1); a_wdata = 8'h3C;
        old_w = mword(300);
        mdl[4*300+1] = 8'h3C;
        tick();
        check("R7", b_rdata, old_w);
        a_wr = 0; a_ben = 0;
        tick();
        check("R7", b_rdata, mword(300));
        idle();

        // R8: asynchronous clear during operation, storage kept
        rst_n = 0;
        #1;
        check("R8", {24'h0, a_rdata}, 32'h0);
        check("R8", b_rdata, 32'h0);
        tick();
        rst_n = 1;
        b_rd = 1; b_addr = 10'd300;
        tick();
        check("R8", b_rdata, mword(300));
        idle();
        tick();

        finish_run();
    end

endmodule